// File: doc/BRIEF.md
# SPI Register Command Engine

This block is the device-side engine that serves register access commands arriving over a full-duplex serial link. A shifter outside the block handles chip select and bit timing. It delivers each received 32-bit word with a one-cycle strobe and sends out the word the engine has prepared for the next slot. The engine decodes a command header and checks its odd parity. It then performs a burst of register writes or reads, one access per word slot, and builds the response stream. The response runs one word behind the command: it starts with a zero word that the host discards, then carries the echoed header, then the echoed write data or the read data.

A small register bank sits inside the block and serves one selectable map. Every other address in every map is a hole. A controller built from four named states sequences each command:
- `ST_HEADER` waits for a header word. A strobe in this state leads to `ST_DATA` (good control header) or to `ST_DISCARD` (parity failure or a data-type header).
- `ST_DATA` performs one access per strobe and moves to `ST_TAIL` after the last one.
- `ST_TAIL` absorbs the trailing word and returns to `ST_HEADER`. This allows several commands back to back in one transaction.
- `ST_DISCARD` ignores everything until the transaction ends.

Dropping `txn_active` returns the controller to `ST_HEADER` from any state.

Top module: `spi_regcmd_engine`

## Requirements
- R1: After reset, and one cycle after `txn_active` falls, `miso_word` is zero. The first response slot of a transaction is therefore a zero word.
- R2: The strobe of a good control header loads `miso_word` with that header, with bit 30 replaced by the sticky bad-header flag and bit 0 recomputed so that the whole word has odd parity. The bit 30 the host sends has no effect.
- R3: A header with bit 31 = 0 and bit 29 = 1 writes the next N words (N = bits 7..1 plus one) to the registers starting at map bits 27..24 and address bits 23..8. Each write word is echoed in the following slot.
- R4: A header with bit 29 = 0 reads N registers. Each of the N words after the header is answered by the contents of the next register, and the MOSI value of those words has no effect.
- R5: With bit 28 = 0, the address increases by one after each access and wraps from 0xFFFF to 0x0000.
- R6: With bit 28 = 1, every access of the burst uses the starting address.
- R7: A length field of 0 gives one access, and 127 gives 128 accesses.
- R8: The word after the last data word of a command is ignored and answered by a zero word. The next word is taken as a new header.
- R9: The bank serves addresses 0 to BANK_DEPTH-1 of map BANK_MAP. Register i resets to 0xA5000000 + i. Any other map or address reads as zero and ignores writes.
- R10: A header whose 32 bits have even parity performs no access. Every later word of that transaction is answered by zero and has no effect. The sticky flag is set, appears in bit 30 of the next good header echo, and is then cleared.
- R11: A header with good parity and bit 31 = 1 is not served. The rest of the transaction is answered by zeros and the sticky flag is not touched.
- R12: Several commands may follow one another in a transaction. Dropping `txn_active` in mid-command aborts it, and accesses already made stay in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_active | input | 1 | High while a serial transaction is in progress |
| word_stb | input | 1 | One-cycle strobe: `mosi_word` holds a complete received word |
| mosi_word | input | 32 | Word received from the host |
| miso_word | output | 32 | Word to send to the host in the next slot |

## Verification
The bench builds the engine with BANK_MAP = 3 and BANK_DEPTH = 6. This places the top of the bank inside the span of short bursts, so one burst can cover both served registers and holes. It also makes a 128-register read run far past the bank's end. A wrap burst starting at 0xFFFF lands on register 0, so the 16-bit wrap can be observed through the bank. A map-0 write tests map decoding against the default map.

// File: rtl/spi_regcmd_pkg.sv
package spi_regcmd_pkg;

    typedef enum logic [1:0] {
        ST_HEADER  = 2'd0,
        ST_DATA    = 2'd1,
        ST_TAIL    = 2'd2,
        ST_DISCARD = 2'd3
    } cmd_state_e;

    // Field positions are protocol-defined: the host encodes them.
    typedef struct packed {
        logic        is_data;
        logic        bad_flag;
        logic        write;
        logic        hold;
        logic [3:0]  map;
        logic [15:0] addr;
        logic [6:0]  cnt_m1;
        logic        par;
    } cmd_hdr_t;

    localparam int WORD_W = 32;

    // Rewrites bit 0 so the whole word has odd parity.
    function automatic logic [WORD_W-1:0] seal_odd(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] t;
        t    = w;
        t[0] = 1'b0;
        t[0] = ~(^t);
        return t;
    endfunction

endpackage

// File: rtl/spi_regcmd_decode.sv
module spi_regcmd_decode
    import spi_regcmd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              par_ok,
    output logic              is_data,
    output logic              write,
    output logic              hold,
    output logic [3:0]        map,
    output logic [15:0]       addr,
    output logic [6:0]        cnt_m1
);

    cmd_hdr_t h;

    always_comb begin
        h       = cmd_hdr_t'(word);
        // Parity spans every header bit, including the ignored flag bit.
        par_ok  = ^h;
        is_data = h.is_data;
        write   = h.write;
        hold    = h.hold;
        map     = h.map;
        addr    = h.addr;
        cnt_m1  = h.cnt_m1;
    end

endmodule

// File: rtl/spi_regcmd_fsm.sv
module spi_regcmd_fsm
    import spi_regcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_active,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] mosi_word,
    input  logic              par_ok,
    input  logic              is_data,
    input  logic              write,
    input  logic              hold,
    input  logic [3:0]        map,
    input  logic [15:0]       addr,
    input  logic [6:0]        cnt_m1,
    output logic              acc_we,
    output logic              acc_re,
    output logic [3:0]        acc_map,
    output logic [15:0]       acc_addr,
    output logic [WORD_W-1:0] acc_wdata,
    input  logic [WORD_W-1:0] acc_rdata,
    output logic [WORD_W-1:0] miso_word
);

    cmd_state_e        state_q, state_d;
    logic [15:0]       addr_q;
    logic [3:0]        map_q;
    logic [6:0]        rem_q;
    logic              wr_q;
    logic              hold_q;
    logic              sticky_q;
    logic [WORD_W-1:0] miso_q;
    logic [WORD_W-1:0] echo;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HEADER;
        else        state_q <= state_d;
    end

    // Next state and access strobes
    always_comb begin
        state_d = state_q;
        acc_we  = 1'b0;
        acc_re  = 1'b0;
        if (!txn_active) begin
            state_d = ST_HEADER;
        end else if (word_stb) begin
            unique case (state_q)
                ST_HEADER: begin
                    if (!par_ok || is_data) state_d = ST_DISCARD;
                    else                    state_d = ST_DATA;
                end
                ST_DATA: begin
                    acc_we = wr_q;
                    acc_re = !wr_q;
                    if (rem_q == 7'd0) state_d = ST_TAIL;
                end
                ST_TAIL:    state_d = ST_HEADER;
                ST_DISCARD: state_d = ST_DISCARD;
                default:    state_d = ST_HEADER;
            endcase
        end
    end

    assign acc_map   = map_q;
    assign acc_addr  = addr_q;
    assign acc_wdata = mosi_word;
    assign miso_word = miso_q;

    always_comb begin
        echo     = mosi_word;
        echo[30] = sticky_q;
        echo     = seal_odd(echo);
    end

    // Datapath and response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            map_q    <= '0;
            rem_q    <= '0;
            wr_q     <= 1'b0;
            hold_q   <= 1'b0;
            sticky_q <= 1'b0;
            miso_q   <= '0;
        end else if (!txn_active) begin
            miso_q <= '0;
        end else if (word_stb) begin
            unique case (state_q)
                ST_HEADER: begin
                    if (!par_ok) begin
                        sticky_q <= 1'b1;
                        miso_q   <= '0;
                    end else if (is_data) begin
                        miso_q <= '0;
                    end else begin
                        miso_q   <= echo;
                        sticky_q <= 1'b0;
                        addr_q   <= addr;
                        map_q    <= map;
                        rem_q    <= cnt_m1;
                        wr_q     <= write;
                        hold_q   <= hold;
                    end
                end
                ST_DATA: begin
                    miso_q <= wr_q ? mosi_word : acc_rdata;
                    if (!hold_q) addr_q <= addr_q + 16'd1;
                    rem_q  <= rem_q - 7'd1;
                end
                ST_TAIL:    miso_q <= '0;
                ST_DISCARD: miso_q <= '0;
                default:    miso_q <= '0;
            endcase
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_active |=> miso_q == '0);

    p_one_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_we, acc_re}));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_active && word_stb && state_q == ST_DATA && !hold_q)
        |=> addr_q == $past(addr_q) + 16'd1);

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_active && word_stb && state_q == ST_DATA && hold_q)
        |=> $stable(addr_q));

    p_tail_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TAIL |-> !acc_we && !acc_re);

    p_bad_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_active && word_stb && state_q == ST_HEADER && !par_ok)
        |=> sticky_q && state_q == ST_DISCARD);

    p_discard_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DISCARD |-> !acc_we && !acc_re);

endmodule

// File: rtl/spi_regcmd_bank.sv
module spi_regcmd_bank
    import spi_regcmd_pkg::*;
#(
    parameter int BANK_MAP   = 1,
    parameter int BANK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [3:0]        map,
    input  logic [15:0]       addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int          IDX_W   = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
    localparam logic [16:0] DEPTH_V = 17'(BANK_DEPTH);
    localparam logic [3:0]  MAP_V   = 4'(BANK_MAP);
    localparam logic [31:0] RST_BASE = 32'hA500_0000;

    logic [WORD_W-1:0] mem [BANK_DEPTH];
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign hit = (map == MAP_V) && ({1'b0, addr} < DEPTH_V);
    assign idx = addr[IDX_W-1:0];

    for (genvar i = 0; i < BANK_DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= RST_BASE + 32'(i);
            else if (we && hit && idx == IDX_W'(i))
                mem[i] <= wdata;
        end
    end

    assign rdata = (re && hit) ? mem[idx] : '0;

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit) |=> mem[$past(idx)] == $past(wdata));

endmodule

// File: rtl/spi_regcmd_engine.sv
module spi_regcmd_engine
    import spi_regcmd_pkg::*;
#(
    parameter int BANK_MAP   = 1,
    parameter int BANK_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_active,
    input  logic        word_stb,
    input  logic [31:0] mosi_word,
    output logic [31:0] miso_word
);

    logic        par_ok, is_data, write, hold;
    logic [3:0]  map;
    logic [15:0] addr;
    logic [6:0]  cnt_m1;
    logic        acc_we, acc_re;
    logic [3:0]  acc_map;
    logic [15:0] acc_addr;
    logic [31:0] acc_wdata, acc_rdata;

    spi_regcmd_decode u_decode (
        .word    (mosi_word),
        .par_ok  (par_ok),
        .is_data (is_data),
        .write   (write),
        .hold    (hold),
        .map     (map),
        .addr    (addr),
        .cnt_m1  (cnt_m1)
    );

    spi_regcmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_active (txn_active),
        .word_stb   (word_stb),
        .mosi_word  (mosi_word),
        .par_ok     (par_ok),
        .is_data    (is_data),
        .write      (write),
        .hold       (hold),
        .map        (map),
        .addr       (addr),
        .cnt_m1     (cnt_m1),
        .acc_we     (acc_we),
        .acc_re     (acc_re),
        .acc_map    (acc_map),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .acc_rdata  (acc_rdata),
        .miso_word  (miso_word)
    );

    spi_regcmd_bank #(
        .BANK_MAP   (BANK_MAP),
        .BANK_DEPTH (BANK_DEPTH)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_we),
        .re    (acc_re),
        .map   (acc_map),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .rdata (acc_rdata)
    );

endmodule

// File: tb/test_spi_regcmd_engine.sv
module test_spi_regcmd_engine;

    localparam int MAP   = 3;
    localparam int DEPTH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn = 1'b0;
    logic        stb = 1'b0;
    logic [31:0] mosi = '0;
    logic [31:0] miso;

    always #10 clk = ~clk;

    spi_regcmd_engine #(.BANK_MAP(MAP), .BANK_DEPTH(DEPTH)) i_spi_regcmd_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_active (txn),
        .word_stb   (stb),
        .mosi_word  (mosi),
        .miso_word  (miso)
    );

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        seen = 1'b0;
    logic [31:0] model [DEPTH];
    bit          sticky_m = 1'b0;
    logic [31:0] wbuf [128];
    logic [31:0] trail_w = 32'h2301_0203;
    bit          done = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] seal(input logic [31:0] w);
        logic [31:0] t;
        t = w; t[0] = 1'b0; t[0] = ~(^t);
        return t;
    endfunction

    function automatic bit hit(input logic [3:0] m, input logic [15:0] a);
        return (m == 4'(MAP)) && (int'(a) < DEPTH);
    endfunction

    // Monitor: scoreboard pop one cycle after each strobe edge
    always @(posedge clk) seen <= stb;
    always @(negedge clk) begin
        if (seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1 actual %h expected none (empty scoreboard)", miso);
            end else begin
                check(miso, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic send(input logic [31:0] w, input logic [31:0] e, input string t);
        @(negedge clk);
        mosi = w; stb = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic begin_txn();
        @(negedge clk); txn = 1'b1;
        @(negedge clk); check(miso, 32'h0, "R1");
    endtask

    task automatic end_txn();
        @(negedge clk); txn = 1'b0;
        @(negedge clk); check(miso, 32'h0, "R1");
    endtask

    // One command; stop_at >= 0 stops before that data word (abort, no trailing word).
    task automatic run_cmd(input bit wr, input bit hold, input logic [3:0] m,
                           input logic [15:0] a0, input int cnt, input bit hb,
                           input int stop_at, input string tag);
        logic [31:0] h, e, d;
        logic [15:0] a;
        h = seal({1'b0, hb, wr, hold, m, a0, 7'(cnt - 1), 1'b0});
        e = h; e[30] = sticky_m; e = seal(e);
        sticky_m = 1'b0;
        send(h, e, "R2");
        a = a0;
        for (int k = 0; k < cnt; k++) begin
            if (k == stop_at) return;
            if (wr) begin
                d = wbuf[k];
                send(d, d, tag);
                if (hit(m, a)) model[int'(a)] = d;
            end else begin
                send($urandom, hit(m, a) ? model[int'(a)] : 32'h0, tag);
            end
            if (!hold) a = a + 16'd1;
        end
        send(trail_w, 32'h0, "R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 actual hung expected completion (watchdog)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] h;
        for (int i = 0; i < DEPTH; i++) model[i] = 32'hA500_0000 + 32'(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(miso, 32'h0, "R1");
        rst_n = 1'b1;

        // R9 reset values, R4 read burst
        begin_txn();
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, DEPTH, 1'b0, -1, "R4");
        end_txn();

        // R3 write burst, then R12 back-to-back read in same transaction
        wbuf[0] = 32'h1111_0001; wbuf[1] = 32'h2222_0002; wbuf[2] = 32'h3333_0003;
        begin_txn();
        run_cmd(1'b1, 1'b0, 4'(MAP), 16'd1, 3, 1'b0, -1, "R3");
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, DEPTH, 1'b0, -1, "R12");
        end_txn();

        // R6 hold address: only last write survives; held read repeats it
        wbuf[0] = 32'hC0DE_0000; wbuf[1] = 32'hC0DE_0001;
        wbuf[2] = 32'hC0DE_0002; wbuf[3] = 32'hC0DE_0003;
        begin_txn();
        run_cmd(1'b1, 1'b1, 4'(MAP), 16'd4, 4, 1'b1, -1, "R6");
        run_cmd(1'b0, 1'b1, 4'(MAP), 16'd4, 3, 1'b0, -1, "R6");
        end_txn();

        // R9 holes: burst crossing the bank end, and another map
        wbuf[0] = 32'h5555_AAAA; wbuf[1] = 32'hDEAD_0006;
        wbuf[2] = 32'hDEAD_0007; wbuf[3] = 32'hDEAD_0008;
        begin_txn();
        run_cmd(1'b1, 1'b0, 4'(MAP), 16'd5, 4, 1'b0, -1, "R9");
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd4, 5, 1'b0, -1, "R9");
        wbuf[0] = 32'hBAD0_BAD0;
        run_cmd(1'b1, 1'b0, 4'd0, 16'd0, 1, 1'b0, -1, "R9");
        run_cmd(1'b0, 1'b0, 4'd0, 16'd0, 1, 1'b0, -1, "R9");
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, 1, 1'b0, -1, "R9");
        end_txn();

        // R7 single access and maximum length
        wbuf[0] = 32'h0707_0707;
        begin_txn();
        run_cmd(1'b1, 1'b0, 4'(MAP), 16'd2, 1, 1'b0, -1, "R7");
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, 128, 1'b0, -1, "R7");
        end_txn();

        // R5 wrap from 0xFFFF to 0
        wbuf[0] = 32'hFFFF_0000; wbuf[1] = 32'h0000_5A5A;
        begin_txn();
        run_cmd(1'b1, 1'b0, 4'(MAP), 16'hFFFF, 2, 1'b0, -1, "R5");
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'hFFFF, 3, 1'b0, -1, "R5");
        end_txn();

        // R8 trailing word looks like a write header: must not act
        wbuf[0] = 32'h0808_0808;
        trail_w = seal({1'b0, 1'b0, 1'b1, 1'b0, 4'(MAP), 16'd1, 7'd0, 1'b0});
        begin_txn();
        run_cmd(1'b1, 1'b0, 4'(MAP), 16'd3, 1, 1'b0, -1, "R8");
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, 4, 1'b0, -1, "R8");
        end_txn();
        trail_w = 32'h0;

        // R10 bad parity: discard rest, flag in next echo then cleared
        h = seal({1'b0, 1'b0, 1'b1, 1'b0, 4'(MAP), 16'd0, 7'd0, 1'b0});
        begin_txn();
        send(h ^ 32'h1, 32'h0, "R10");
        send(32'h9999_9999, 32'h0, "R10");
        send(h, 32'h0, "R10");
        send(32'h7777_7777, 32'h0, "R10");
        end_txn();
        sticky_m = 1'b1;
        begin_txn();
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, 2, 1'b0, -1, "R10");
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, 1, 1'b1, -1, "R10");
        end_txn();

        // R11 data-type header with good parity: ignored, flag untouched
        h = seal({1'b1, 1'b0, 1'b1, 1'b0, 4'(MAP), 16'd0, 7'd1, 1'b0});
        begin_txn();
        send(h, 32'h0, "R11");
        send(32'h4444_4444, 32'h0, "R11");
        send(32'h5555_5555, 32'h0, "R11");
        end_txn();
        begin_txn();
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd0, 2, 1'b0, -1, "R11");
        end_txn();

        // R12 abort in mid-write: first two writes land, rest unchanged
        wbuf[0] = 32'hAB00_0001; wbuf[1] = 32'hAB00_0002; wbuf[2] = 32'hAB00_0003;
        begin_txn();
        run_cmd(1'b1, 1'b0, 4'(MAP), 16'd2, 4, 1'b0, 2, "R12");
        end_txn();
        begin_txn();
        run_cmd(1'b0, 1'b0, 4'(MAP), 16'd2, 4, 1'b0, -1, "R12");
        end_txn();

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 actual %0d expected 0 pending responses", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule